// File: doc/BRIEF.md
# External-Trigger ADC Conversion Controller

This block sequences analog-to-digital conversions that are started by an external trigger pin. The pin passes through a two-flop synchronizer, and an edge detector checks it against a programmable edge selection. Once enabled, the controller waits for a valid edge. It then asks the converter core to start a conversion and raises a conversion-in-progress status flag.

When the core reports completion, the core's result is written into the result register of the selected channel. In the same cycle an end-of-conversion interrupt pulses for one cycle, and the controller goes back to waiting for the next edge. Two kinds of event interrupt a running conversion:
- A valid edge during a conversion aborts it and restarts it at once.
- A configuration write during a conversion aborts it and returns the controller to waiting.

Configuration arrives as single-cycle register-write strobes carrying an address and data.

Top module: `extTrigAdcCtl`

## Requirements
- R1: After reset the controller is idle, with convActive, eocIrq and convStart at 0 and all four result registers at zero.
- R2: The trigger pin is sampled by a two-flop synchronizer. Each qualifying pin transition gives exactly one single-cycle convStart, in the second cycle after the pin is first sampled.
- R3: Writing address 0 sets the control register: data bit 0 is enable, and data bits 2:1 select the edge (01 rising only, 10 falling only, 11 both, 00 none). Transitions that are not selected start nothing.
- R4: After enable is set, no conversion starts until a valid edge arrives, and convActive stays 0 while waiting.
- R5: A valid edge while waiting pulses convStart for one cycle, and convActive is 1 from the next cycle.
- R6: coreDone during a conversion stores coreResult in the result register of the current channel. eocIrq pulses for one cycle as the new value appears, convActive returns to 0, and the controller waits again.
- R7: A valid edge during a conversion pulses convAbort and convStart in the same cycle, and convActive stays 1.
- R8: A write to address 0, 1 or 2 during a conversion pulses convAbort, clears convActive and starts nothing. No result is stored and no interrupt is raised.
- R9: Writing address 0 with data bit 0 clear makes the controller idle, and pin edges start nothing until it is re-enabled.
- R10: A write to address 3 is ignored: it does not abort a running conversion.
- R11: In a cycle with a register write, no conversion starts. In a cycle with a valid edge or a register write, coreDone is ignored.
- R12: Writing address 2 sets the channel (data bits 1:0). The channel drives convChan and chooses which result register a completion writes. Address 1 bits 1:0 drive convMode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigPin | input | 1 | Asynchronous external trigger |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 2 | Write address (0 control, 1 mode, 2 channel, 3 none) |
| regWrData | input | 3 | Write data |
| convStart | output | 1 | Start request to converter core |
| convAbort | output | 1 | Abort request to converter core |
| convChan | output | 2 | Channel being converted |
| convMode | output | 2 | Mode field passed to the core |
| coreDone | input | 1 | Core completion pulse |
| coreResult | input | 10 | Core conversion result |
| convActive | output | 1 | Conversion-in-progress flag |
| eocIrq | output | 1 | End-of-conversion interrupt pulse |
| results | output | 4x10 | Per-channel result registers |

## Verification
The assertions check these rules on every cycle:
- A start is followed by an active conversion.
- The interrupt lasts one cycle and never coincides with the active flag.
- A restart always carries an abort.
- A configuration write or a disable stops a conversion.
- An address-3 write never aborts.

Some behaviours only the bench's scenarios can show: the exact synchronizer latency, the effect of each edge-select code, which result register receives each value, and how the outcome depends on when a done pulse, an edge and a write line up in time. A cycle-accurate reference model produces all of these.

// File: rtl/extTrigAdcPkg.sv
package extTrigAdcPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CONV = 2'd2
  } ctlState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic start;
    logic abort;
    logic capture;
  } ctlStrobe_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_MODE = 2'd1;
  localparam logic [1:0] ADDR_CHAN = 2'd2;

endpackage

// File: rtl/adcTrigEdge.sv
module adcTrigEdge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinIn,
  input  logic [1:0] edgeSel,
  output logic       trigPulse
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   syncOut;
  logic                   riseDet;
  logic                   fallDet;

  generate
    if (SYNC_STAGES == 1) begin : gSingle
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= pinIn;
      end
    end else begin : gChain
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
      end
    end
  endgenerate

  assign syncOut = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncOut;
  end

  assign riseDet   = syncOut & ~prevQ;
  assign fallDet   = ~syncOut & prevQ;
  assign trigPulse = (edgeSel[0] & riseDet) | (edgeSel[1] & fallDet);

endmodule

// File: rtl/adcTrigCtrl.sv
module adcTrigCtrl
  import extTrigAdcPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [1:0] regWrAddr,
  input  logic       enBit,
  input  logic       trigPulse,
  input  logic       coreDone,
  output ctlStrobe_t strobes,
  output logic       convActive
);

  ctlState_t stateQ;
  ctlState_t stateD;
  logic      wrHit;
  logic      ctlWr;
  logic      running;
  logic      inConv;

  assign wrHit   = regWrEn && (regWrAddr <= ADDR_CHAN);
  assign ctlWr   = regWrEn && (regWrAddr == ADDR_CTRL);
  assign running = (stateQ != ST_IDLE);
  assign inConv  = (stateQ == ST_CONV);

  always_comb begin
    strobes.start   = running && trigPulse && !wrHit;
    strobes.abort   = inConv && (wrHit || trigPulse);
    strobes.capture = inConv && coreDone && !wrHit && !trigPulse;
  end

  always_comb begin
    stateD = stateQ;
    if (ctlWr) begin
      stateD = enBit ? ST_WAIT : ST_IDLE;
    end else if (wrHit) begin
      if (inConv) stateD = ST_WAIT;
    end else if (strobes.start) begin
      stateD = ST_CONV;
    end else if (strobes.capture) begin
      stateD = ST_WAIT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign convActive = inConv;

endmodule

// File: rtl/adcTrigDatapath.sv
module adcTrigDatapath
  import extTrigAdcPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int RES_W  = 10,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         regWrEn,
  input  logic [1:0]                   regWrAddr,
  input  logic [2:0]                   regWrData,
  input  ctlStrobe_t                   strobes,
  input  logic [RES_W-1:0]             coreResult,
  output logic [1:0]                   edgeSel,
  output logic [1:0]                   convMode,
  output logic [CH_W-1:0]              convChan,
  output logic                         eocIrq,
  output logic [NUM_CH-1:0][RES_W-1:0] results
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgeSel  <= 2'b00;
      convMode <= 2'b00;
      convChan <= '0;
    end else if (regWrEn) begin
      case (regWrAddr)
        ADDR_CTRL: edgeSel  <= regWrData[2:1];
        ADDR_MODE: convMode <= regWrData[1:0];
        ADDR_CHAN: convChan <= regWrData[CH_W-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) eocIrq <= 1'b0;
    else       eocIrq <= strobes.capture;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gResult
    always_ff @(posedge clk) begin
      if (!rstN)
        results[ch] <= '0;
      else if (strobes.capture && (convChan == CH_W'(ch)))
        results[ch] <= coreResult;
    end
  end

endmodule

// File: rtl/extTrigAdcCtl.sv
module extTrigAdcCtl
  import extTrigAdcPkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int RES_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         trigPin,
  input  logic                         regWrEn,
  input  logic [1:0]                   regWrAddr,
  input  logic [2:0]                   regWrData,
  output logic                         convStart,
  output logic                         convAbort,
  output logic [$clog2(NUM_CH)-1:0]    convChan,
  output logic [1:0]                   convMode,
  input  logic                         coreDone,
  input  logic [RES_W-1:0]             coreResult,
  output logic                         convActive,
  output logic                         eocIrq,
  output logic [NUM_CH-1:0][RES_W-1:0] results
);

  localparam int CH_W = $clog2(NUM_CH);

  logic       trigPulse;
  logic [1:0] edgeSel;
  ctlStrobe_t strobes;

  adcTrigEdge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (trigPin),
    .edgeSel  (edgeSel),
    .trigPulse(trigPulse)
  );

  adcTrigCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrAddr (regWrAddr),
    .enBit     (regWrData[0]),
    .trigPulse (trigPulse),
    .coreDone  (coreDone),
    .strobes   (strobes),
    .convActive(convActive)
  );

  adcTrigDatapath #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CH_W(CH_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrAddr (regWrAddr),
    .regWrData (regWrData),
    .strobes   (strobes),
    .coreResult(coreResult),
    .edgeSel   (edgeSel),
    .convMode  (convMode),
    .convChan  (convChan),
    .eocIrq    (eocIrq),
    .results   (results)
  );

  assign convStart = strobes.start;
  assign convAbort = strobes.abort;

endmodule

// File: rtl/extTrigAdcCtl_chk.sv
module extTrigAdcCtl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic [1:0] regWrAddr,
  input logic       ctlEnBit,
  input logic       convStart,
  input logic       convAbort,
  input logic       convActive,
  input logic       eocIrq
);

  assert_start_then_active_R5: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> convActive);

  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    eocIrq |=> !eocIrq);

  assert_irq_not_active_R6: assert property (@(posedge clk) disable iff (!rstN)
    eocIrq |-> !convActive);

  assert_restart_aborts_R7: assert property (@(posedge clk) disable iff (!rstN)
    (convActive && convStart) |-> convAbort);

  assert_cfg_write_stops_R8: assert property (@(posedge clk) disable iff (!rstN)
    (convActive && regWrEn && (regWrAddr != 2'd3)) |=> (!convActive && !eocIrq));

  assert_disable_idles_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (regWrAddr == 2'd0) && !ctlEnBit) |=> (!convActive && !convStart));

  assert_addr3_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (convActive && regWrEn && (regWrAddr == 2'd3) && !convStart) |-> !convAbort);

  assert_write_blocks_start_R11: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (regWrAddr != 2'd3)) |-> !convStart);

endmodule

bind extTrigAdcCtl extTrigAdcCtl_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regWrAddr (regWrAddr),
  .ctlEnBit  (regWrData[0]),
  .convStart (convStart),
  .convAbort (convAbort),
  .convActive(convActive),
  .eocIrq    (eocIrq)
);

// File: tb/extTrigAdcCtl_bench.sv
module extTrigAdcCtl_bench;

  localparam int NUM_CH = 4;
  localparam int RES_W  = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                         rstN = 1'b0;
  logic                         trigPin = 1'b0;
  logic                         regWrEn = 1'b0;
  logic [1:0]                   regWrAddr = 2'd0;
  logic [2:0]                   regWrData = 3'd0;
  logic                         convStart, convAbort, convActive, eocIrq;
  logic [1:0]                   convChan, convMode;
  logic                         coreDone = 1'b0;
  logic [RES_W-1:0]             coreResult = '0;
  logic [NUM_CH-1:0][RES_W-1:0] results;

  extTrigAdcCtl #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_extTrigAdcCtl (
    .clk(clk), .rstN(rstN), .trigPin(trigPin),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .convStart(convStart), .convAbort(convAbort), .convChan(convChan),
    .convMode(convMode), .coreDone(coreDone), .coreResult(coreResult),
    .convActive(convActive), .eocIrq(eocIrq), .results(results)
  );

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  string curTag = "R1";
  bit    finished = 0;

  // Reference model state (0 idle, 1 waiting, 2 converting)
  bit             mS1, mS2, mPrev;
  int             mState;
  bit [1:0]       mEdge, mMode, mChan;
  bit [RES_W-1:0] mRes [NUM_CH];
  bit             mIrq;

  function automatic bit mTrig();
    bit rise, fall;
    rise = mS2 && !mPrev;
    fall = !mS2 && mPrev;
    return (mEdge[0] && rise) || (mEdge[1] && fall);
  endfunction

  function automatic bit wrHitNow();
    return regWrEn && (regWrAddr != 2'd3);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mS1 = 0; mS2 = 0; mPrev = 0; mState = 0;
      mEdge = 0; mMode = 0; mChan = 0; mIrq = 0;
      for (int i = 0; i < NUM_CH; i++) mRes[i] = '0;
    end else begin
      bit trig, hit, cap, st;
      trig = mTrig();
      hit  = wrHitNow();
      cap  = (mState == 2) && coreDone && !hit && !trig;
      st   = (mState != 0) && trig && !hit;
      mIrq = cap;
      if (cap) mRes[mChan] = coreResult;
      if (hit && regWrAddr == 2'd0) begin
        mEdge  = regWrData[2:1];
        mState = regWrData[0] ? 1 : 0;
      end else if (hit) begin
        if (regWrAddr == 2'd1) mMode = regWrData[1:0];
        else                   mChan = regWrData[1:0];
        if (mState == 2) mState = 1;
      end else if (st) begin
        mState = 2;
      end else if (cap) begin
        mState = 1;
      end
      mPrev = mS2; mS2 = mS1; mS1 = trigPin;
    end
  end

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", curTag, what, act, exp, $time);
    end
  endtask

  // Converter core stub
  int stubLat = 6;
  int stubCnt = 0;
  int stubSeq = 0;

  always @(negedge clk) begin
    #1;
    if (rstN && !finished) begin
      bit expStart, expAbort;
      expStart = (mState != 0) && mTrig() && !wrHitNow();
      expAbort = (mState == 2) && (wrHitNow() || mTrig());
      chk("convStart", convStart, expStart);
      chk("convAbort", convAbort, expAbort);
      chk("convActive", convActive, mState == 2);
      chk("eocIrq", eocIrq, mIrq);
      chk("convChan", convChan, mChan);
      chk("convMode", convMode, mMode);
      for (int i = 0; i < NUM_CH; i++) chk("result", results[i], mRes[i]);
    end
    if (!rstN) begin
      stubCnt = 0;
    end else if (convStart) begin
      stubCnt = stubLat;
      stubSeq++;
    end else if (convAbort) begin
      stubCnt = 0;
    end else if (stubCnt > 0) begin
      stubCnt--;
    end
    coreDone   = (stubCnt == 1);
    coreResult = RES_W'(37 * stubSeq + 5 * convChan + 1);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=done", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [2:0] d);
    @(negedge clk);
    regWrEn = 1; regWrAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic flip();
    @(negedge clk);
    trigPin = ~trigPin;
  endtask

  initial begin
    idle(3);
    rstN = 1;
    curTag = "R1";
    idle(4);

    curTag = "R4";
    wr(2'd0, 3'b011);
    idle(8);

    curTag = "R2";
    flip(); idle(3);
    curTag = "R6";
    idle(10);
    flip(); idle(12);

    curTag = "R12";
    wr(2'd2, 3'd2);
    wr(2'd1, 3'd3);
    curTag = "R3";
    wr(2'd0, 3'b101);
    flip(); idle(12);
    flip(); idle(12);
    wr(2'd0, 3'b111);
    for (int c = 0; c < 4; c++) begin
      wr(2'd2, 3'(c));
      flip(); idle(12);
    end
    wr(2'd0, 3'b001);
    flip(); idle(6); flip(); idle(6);

    curTag = "R7";
    wr(2'd0, 3'b111);
    stubLat = 12;
    for (int d = 1; d < 15; d++) begin
      flip(); idle(d); flip(); idle(20);
    end

    curTag = "R8";
    for (int a = 0; a < 3; a++) begin
      flip(); idle(4);
      wr(2'(a), (a == 0) ? 3'b111 : 3'd1);
      idle(16);
    end

    curTag = "R10";
    flip(); idle(4);
    wr(2'd3, 3'b000);
    idle(16);

    curTag = "R9";
    flip(); idle(4);
    wr(2'd0, 3'b110);
    flip(); idle(6); flip(); idle(6);
    wr(2'd0, 3'b111);
    idle(4);

    curTag = "R11";
    stubLat = 5;
    for (int d = 0; d < 8; d++) begin
      flip(); idle(d);
      @(negedge clk);
      regWrEn = 1; regWrAddr = 2'd1; regWrData = 3'(d);
      trigPin = ~trigPin;
      @(negedge clk);
      regWrEn = 0;
      idle(12);
    end
    for (int d = 0; d < 8; d++) begin
      wr(2'd0, 3'b111);
      flip(); idle(d);
      wr(2'd0, 3'b011);
      idle(3); flip();
      idle(12);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule